// File: doc/BRIEF.md
# Vector Half-Group Element Mover

This unit rearranges elements between two vector registers so that a radix-2 FFT can keep every vector operation at full length in its late stages. Each operation reads a source vector and the current contents of a destination vector. It returns the new destination value, which is registered behind a valid/ready handshake.

The mover has three operations. A plain copy returns the source unchanged. A half-up move splits both vectors into groups of 2k elements and writes the lower k source elements of each group into the upper k slots of that group in the destination. A half-down move writes the upper k source elements of each group into the lower k slots. The destination slots that are not written keep their old values. A full exchange between registers A and B takes three steps: copy A to a temporary C, half-up B into A, then half-down C into B. Halving k after each FFT stage makes the exchange interleave more finely.

Elements are 16, 32 or 64 bits wide, chosen per operation. The group size is given as log2(k). The internal control has two states:
- EMPTY: no result is held.
- FULL: a result is held.

Transitions:
- ACCEPT moves EMPTY to FULL.
- REFILL keeps the block in FULL when a held result drains and a new operation is accepted in the same cycle.
- STALL keeps the block in FULL when the held result is not taken.
- DRAIN moves FULL to EMPTY when the held result is taken and no new operation is accepted.

Top module: `hgm_mover`

## Requirements
- R1: The width field selects the element width and the element count of a vector of VBITS bits: 2'b00 gives 16-bit elements, 2'b01 gives 32-bit, 2'b10 gives 64-bit, and 2'b11 is reserved. With the default VBITS=2048 the counts are 128, 64 and 32.
- R2: Opcode 2'b00 (copy) produces the source vector unchanged, with the error flag low, for any group-size value.
- R3: Opcode 2'b01 (half-up), with k = 2^grp, produces for each element i at position p = i mod 2k: the source element i-k when p >= k, and the destination element i otherwise.
- R4: Opcode 2'b10 (half-down) produces for each element i at position p = i mod 2k: the source element i+k when p < k, and the destination element i otherwise.
- R5: For a half-up or half-down operation where 2k exceeds the element count of the selected width, the result equals the destination input and the error flag is high.
- R6: Opcode 2'b11 or width 2'b11 produces the destination input unchanged, with the error flag high. The error flag is high only on that one result beat.
- R7: A result is presented on out_valid exactly one cycle after its operation is accepted (in_valid and in_ready both high at a clock edge).
- R8: in_ready is high when no result is held or out_ready is high. While out_valid is high and out_ready is low, out_vec and out_err stay stable. One operation can be accepted per cycle when out_ready is high.
- R9: In 64-bit mode with k=4 (grp=2), starting from A elements 0..31 and B elements 32..63, the sequence copy A to C, half-up B into A, half-down C into B leaves A[i] = i when i mod 8 < 4 and 28+i otherwise, and B[i] = i+4 when i mod 8 < 4 and 32+i otherwise.
- R10: After reset, out_valid and out_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request valid |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 2 | Opcode: 00 copy, 01 half-up, 10 half-down, 11 reserved |
| in_width | input | 2 | Element width: 00 16-bit, 01 32-bit, 10 64-bit, 11 reserved |
| in_grp | input | GW (3) | log2 of the half-group size k |
| in_src | input | VBITS (2048) | Source vector |
| in_dst | input | VBITS (2048) | Current destination vector |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | VBITS (2048) | New destination vector |
| out_err | output | 1 | The operation was rejected and the destination was kept |

## Verification
The bench builds the mover with VBITS=2048 and GW=3. These defaults give 128, 64 and 32 elements per width. A 3-bit group field then reaches every legal group size up to the full register in each width, and it also reaches values that are too large by one or more steps in each width. Those too-large values exercise the rejection path with real data in every width. Random backpressure on out_ready drives the stall and refill transitions. The swap sequence checks the exchange pattern against an explicit element formula.

// File: rtl/hgm_pkg.sv
package hgm_pkg;

    typedef enum logic [1:0] {
        HGM_OP_COPY = 2'b00,
        HGM_OP_HUP  = 2'b01,
        HGM_OP_HDN  = 2'b10,
        HGM_OP_RSVD = 2'b11
    } hgm_op_e;

    typedef enum logic [1:0] {
        HGM_EW16   = 2'b00,
        HGM_EW32   = 2'b01,
        HGM_EW64   = 2'b10,
        HGM_EWRSVD = 2'b11
    } hgm_ew_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hgm_state_e;

    localparam int HGM_NUM_EW  = 3;
    localparam int HGM_BASE_EW = 16;

endpackage

// File: rtl/hgm_legal.sv
module hgm_legal
    import hgm_pkg::*;
#(
    parameter int VBITS = 2048,
    parameter int GW    = 3
) (
    input  hgm_op_e        op,
    input  hgm_ew_e        ew,
    input  logic [GW-1:0]  grp,
    output logic           err
);
    localparam int CNT16 = VBITS / HGM_BASE_EW;
    localparam int CNT32 = VBITS / (2 * HGM_BASE_EW);
    localparam int CNT64 = VBITS / (4 * HGM_BASE_EW);

    logic [31:0] count;
    logic [31:0] span;

    always_comb begin
        unique case (ew)
            HGM_EW16: count = 32'(CNT16);
            HGM_EW32: count = 32'(CNT32);
            HGM_EW64: count = 32'(CNT64);
            default:  count = 32'd0;
        endcase
        span = 32'd2 << grp;
        err  = (ew == HGM_EWRSVD) || (op == HGM_OP_RSVD) ||
               ((op != HGM_OP_COPY) && (span > count));
    end
endmodule

// File: rtl/hgm_route.sv
module hgm_route
    import hgm_pkg::*;
#(
    parameter int VBITS = 2048,
    parameter int EW    = 16,
    parameter int GW    = 3
) (
    input  hgm_op_e          op,
    input  logic [GW-1:0]    grp,
    input  logic [VBITS-1:0] src,
    input  logic [VBITS-1:0] dst,
    output logic [VBITS-1:0] vec
);
    localparam int N  = VBITS / EW;
    localparam int IW = $clog2(N);

    logic [EW-1:0] src_el [N];

    for (genvar e = 0; e < N; e++) begin : g_unpack
        assign src_el[e] = src[e*EW +: EW];
    end

    for (genvar e = 0; e < N; e++) begin : g_elem
        localparam logic [IW-1:0] IDX = IW'(e);
        logic [IW-1:0] stride;
        logic [IW-1:0] partner;
        logic          upper;
        logic          take;

        always_comb begin
            stride  = IW'(1) << grp;
            partner = IDX ^ stride;
            upper   = |(IDX & stride);
            take    = ((op == HGM_OP_HUP) && upper) ||
                      ((op == HGM_OP_HDN) && !upper);
        end

        assign vec[e*EW +: EW] = take ? src_el[partner] : dst[e*EW +: EW];
    end
endmodule

// File: rtl/hgm_mover.sv
module hgm_mover
    import hgm_pkg::*;
#(
    parameter int VBITS = 2048,
    parameter int GW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_op,
    input  logic [1:0]       in_width,
    input  logic [GW-1:0]    in_grp,
    input  logic [VBITS-1:0] in_src,
    input  logic [VBITS-1:0] in_dst,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VBITS-1:0] out_vec,
    output logic             out_err
);
    hgm_op_e    op;
    hgm_ew_e    ew;
    hgm_state_e state_q, state_d;
    logic       accept, drain, bad;
    logic [VBITS-1:0] routed [HGM_NUM_EW];
    logic [VBITS-1:0] next_vec;

    assign op = hgm_op_e'(in_op);
    assign ew = hgm_ew_e'(in_width);

    hgm_legal #(.VBITS(VBITS), .GW(GW)) u_legal (
        .op (op),
        .ew (ew),
        .grp(in_grp),
        .err(bad)
    );

    for (genvar w = 0; w < HGM_NUM_EW; w++) begin : g_width
        hgm_route #(.VBITS(VBITS), .EW(HGM_BASE_EW << w), .GW(GW)) u_route (
            .op (op),
            .grp(in_grp),
            .src(in_src),
            .dst(in_dst),
            .vec(routed[w])
        );
    end

    always_comb begin
        if (bad) begin
            next_vec = in_dst;
        end else if (op == HGM_OP_COPY) begin
            next_vec = in_src;
        end else begin
            unique case (ew)
                HGM_EW16: next_vec = routed[0];
                HGM_EW32: next_vec = routed[1];
                HGM_EW64: next_vec = routed[2];
                default:  next_vec = in_dst;
            endcase
        end
    end

    assign in_ready = (state_q == ST_EMPTY) || out_ready;
    assign accept   = in_valid && in_ready;
    assign drain    = (state_q == ST_FULL) && out_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;
            ST_FULL:  if (drain && !accept) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vec <= '0;
            out_err <= 1'b0;
        end else if (accept) begin
            out_vec <= next_vec;
            out_err <= bad;
        end
    end

    assign out_valid = (state_q == ST_FULL);
endmodule

// File: rtl/hgm_mover_chk.sv
module hgm_mover_chk #(
    parameter int VBITS = 2048,
    parameter int GW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       in_op,
    input logic [1:0]       in_width,
    input logic [GW-1:0]    in_grp,
    input logic [VBITS-1:0] in_src,
    input logic [VBITS-1:0] in_dst,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VBITS-1:0] out_vec,
    input logic             out_err
);
    logic acc;
    assign acc = in_valid && in_ready;

    p_accept_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);

    p_rise_needs_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(acc));

    p_ready_when_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_ready) |-> in_ready);

    p_stall_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vec) && $stable(out_err)));

    p_copy_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op == 2'b00 && in_width != 2'b11) |=> (!out_err && out_vec == $past(in_src)));

    p_reserved_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (in_op == 2'b11 || in_width == 2'b11)) |=> (out_err && out_vec == $past(in_dst)));

    p_err_keeps_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op != 2'b00 && in_width == 2'b10 && in_grp >= 3'd5) |=> (out_err && out_vec == $past(in_dst)));
endmodule

bind hgm_mover hgm_mover_chk #(.VBITS(VBITS), .GW(GW)) u_chk (.*);

// File: tb/hgm_mover_bench.sv
module hgm_mover_bench;
    localparam int VB = 2048;
    localparam int GW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [1:0]    in_op = 2'b00;
    logic [1:0]    in_width = 2'b00;
    logic [GW-1:0] in_grp = '0;
    logic [VB-1:0] in_src = '0;
    logic [VB-1:0] in_dst = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [VB-1:0] out_vec;
    logic          out_err;

    int n_vec = 0;
    int n_bad = 0;
    bit rand_ready = 1'b0;

    // reference state
    bit            m_valid = 1'b0;
    logic [VB-1:0] m_vec = '0;
    bit            m_err = 1'b0;
    string         m_tag = "R10";

    always #2 clk = ~clk;

    hgm_mover #(.VBITS(VB), .GW(GW)) u_hgm_mover (.*);

    function automatic void ref_apply(input int op, input int w, input int g,
                                      input logic [VB-1:0] s, input logic [VB-1:0] d,
                                      output logic [VB-1:0] r, output bit e,
                                      output string tag);
        int ew, n, k, pos;
        r = d; e = 1'b0;
        tag = (op == 0) ? "R2" : (op == 1) ? "R3" : "R4";
        if (op == 3 || w == 3) begin e = 1'b1; tag = "R6"; return; end
        if (op == 0) begin r = s; return; end
        ew = 16 << w;         // R1: 16/32/64-bit elements
        n  = VB / ew;
        k  = 1 << g;
        if (2 * k > n) begin e = 1'b1; tag = "R5"; return; end
        for (int i = 0; i < n; i++) begin
            pos = i % (2 * k);
            if (op == 1 && pos >= k)
                for (int b = 0; b < ew; b++) r[i*ew + b] = s[(i-k)*ew + b];
            if (op == 2 && pos < k)
                for (int b = 0; b < ew; b++) r[i*ew + b] = s[(i+k)*ew + b];
        end
    endfunction

    always @(negedge clk) begin
        logic [VB-1:0] rv;
        bit re;
        string rt;
        n_vec++;
        if (out_valid !== m_valid) begin
            n_bad++;
            $display("FAIL R7 out_valid actual=%0b expected=%0b", out_valid, m_valid);
        end else if (m_valid && (out_vec !== m_vec || out_err !== m_err)) begin
            n_bad++;
            $display("FAIL %s out_vec actual=%h expected=%h err actual=%0b expected=%0b",
                     m_tag, out_vec, m_vec, out_err, m_err);
        end
        if (rst_n && in_ready !== (!m_valid || out_ready)) begin
            n_bad++;
            $display("FAIL R8 in_ready actual=%0b expected=%0b", in_ready, !m_valid || out_ready);
        end
        if (!rst_n) begin
            m_valid = 1'b0;
        end else if (in_valid && (!m_valid || out_ready)) begin
            ref_apply(int'(in_op), int'(in_width), int'(in_grp), in_src, in_dst, rv, re, rt);
            m_vec = rv; m_err = re; m_tag = rt; m_valid = 1'b1;
        end else if (m_valid && out_ready) begin
            m_valid = 1'b0;
        end
    end

    always @(posedge clk) begin
        #1;
        if (rand_ready) out_ready <= ($urandom % 3) != 0;
        else            out_ready <= 1'b1;
    end

    function automatic logic [VB-1:0] rnd_vec();
        logic [VB-1:0] v;
        for (int i = 0; i < VB / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic send(input int op, input int w, input int g,
                        input logic [VB-1:0] s, input logic [VB-1:0] d,
                        output logic [VB-1:0] res);
        bit took;
        in_valid = 1'b1; in_op = 2'(op); in_width = 2'(w); in_grp = GW'(g);
        in_src = s; in_dst = d;
        took = 1'b0;
        while (!took) begin
            @(negedge clk);
            took = in_ready;
            @(posedge clk); #1;
        end
        res = out_vec;
        in_valid = 1'b0;
    endtask

    function automatic void check_vec(input string tag, input logic [VB-1:0] act,
                                      input logic [VB-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    initial begin
        logic [VB-1:0] r, a, b, c, ea, eb;
        fork
            begin
                repeat (200000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog expired");
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        join_none

        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        n_vec++;
        if (out_valid !== 1'b0 || out_err !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 out_valid=%0b out_err=%0b expected 0 0", out_valid, out_err);
        end
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1..R6: every width, opcode and group-size value, streamed
        for (int w = 0; w < 4; w++)
            for (int op = 0; op < 4; op++)
                for (int g = 0; g < 8; g++)
                    send(op, w, g, rnd_vec(), rnd_vec(), r);

        // R8: same sweep under random backpressure
        rand_ready = 1'b1;
        for (int rep = 0; rep < 2; rep++)
            for (int w = 0; w < 3; w++)
                for (int op = 1; op < 3; op++)
                    for (int g = 0; g < 8; g++)
                        send(op, w, g, rnd_vec(), rnd_vec(), r);
        rand_ready = 1'b0;
        repeat (4) @(posedge clk);
        #1;

        // R9: three-step swap, 64-bit elements, k=4
        for (int i = 0; i < 32; i++) begin
            a[i*64 +: 64] = 64'(i);
            b[i*64 +: 64] = 64'(32 + i);
            ea[i*64 +: 64] = (i % 8 < 4) ? 64'(i)     : 64'(28 + i);
            eb[i*64 +: 64] = (i % 8 < 4) ? 64'(i + 4) : 64'(32 + i);
        end
        send(0, 2, 2, a, rnd_vec(), c);
        check_vec("R9 copy", c, a);
        send(1, 2, 2, b, a, a);
        send(2, 2, 2, c, b, b);
        check_vec("R9 A after swap", a, ea);
        check_vec("R9 B after swap", b, eb);
        @(posedge clk); #1;
        @(posedge clk); #1;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule